// File: doc/BRIEF.md
# Nibble Transmit Serializer with Per-Slice Tristate Select

This block forms the transmit side of a six-slice nibble. On every word boundary it takes one parallel data word per slice plus a shared write-enable word, then shifts them out one bit per fast clock. The word length is 8, 4 or 2 bits and is set by a run-time ratio select. Each slice drives one serial data bit and one tristate control bit.

The tristate bit of each slice comes from one of two sources, picked per slice:
- the raw `t_in` bit, routed combinationally and not aligned to the data;
- the write-enable word, inverted and serialized in step with the data, so the driver turns on exactly for the enabled bits.

The write-enable source is not allowed at the 2:1 ratio. A slice configured that way reports `cfg_err` and falls back to `t_in`.

An optional gating mode forces serial data to zero wherever the serialized write-enable bit is low. One slice, slice 1 by default, is exempt from gating.

The block has a single fast clock. The divided word clock is represented by the `word_ld` strobe, which the block generates itself.

Top module: `nibble_tx_serializer`

## Requirements
- R1: The ratio select maps 2'b00 to 2:1, 2'b01 to 4:1, and 2'b10 or 2'b11 to 8:1. The word length R is 2, 4 or 8 bits.
- R2: `word_ld` is high in the cycle before each load edge and fires once every R cycles. The first load happens on the first clock edge after reset is released.
- R3: On a load edge, each slice captures bits 0..R-1 of its `tx_data` byte (slice x uses bits 8x+7..8x) and the write-enable word `tx_wren`. Data bit k appears on `ser_out[x]` during the k-th cycle after the load edge, starting with k = 0, so the least significant bit goes first.
- R4: When `tsrc_sel[x]` is 0, `t_out[x]` equals `t_in[x]` in the same cycle, with no register in the path.
- R5: When `tsrc_sel[x]` is 1 and the ratio is not 2:1, `t_out[x]` is the inverse of the write-enable bit that is serialized alongside the current data bit.
- R6: At the 2:1 ratio, `cfg_err` is high whenever any `tsrc_sel` bit is set, and every slice's `t_out` follows `t_in`. At other ratios `cfg_err` is low.
- R7: When `gate_en` is 1, `ser_out[x]` is the serialized data bit ANDed with the serialized write-enable bit, so it is 0 while the enable bit is low.
- R8: Slice 1 is never gated. Its `ser_out` carries the data bit whatever `gate_en` and `tx_wren` are.
- R9: During reset and until the first load, `ser_out` is all zeros. A slice selecting the write-enable source shows `t_out` = 1 (driver off) during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | 2 | Serialization ratio select |
| gate_en | input | 1 | Enables gating of data by the write-enable |
| tsrc_sel | input | 6 | Per-slice tristate source: 0 = t_in, 1 = write-enable |
| tx_data | input | 48 | Parallel data, one byte per slice |
| tx_wren | input | 8 | Parallel write-enable word, one bit per serial position |
| t_in | input | 6 | Direct combinational tristate inputs |
| word_ld | output | 1 | High in the cycle before a word load edge |
| ser_out | output | 6 | Serial data, one bit per slice |
| t_out | output | 6 | Tristate control, one bit per slice |
| cfg_err | output | 1 | Write-enable source selected at the 2:1 ratio |

## Verification
The in-design assertions check on every cycle that:
- the bit counter stays inside the word and `word_ld` never fires in back-to-back cycles;
- unselected slices pass `t_in` through, and every slice passes `t_in` through at 2:1;
- `cfg_err` appears only at 2:1;
- a gated slice whose tristate bit shows a low enable emits zero.

Three behaviours can only be shown by the bench's scenarios, because they depend on data captured several cycles earlier:
- the actual bit order on the line;
- the alignment of the inverted enable with each data bit;
- the word period after a ratio change.

The bench's reference model replays these behaviours for random words at all three ratios.

// File: rtl/nts_pkg.sv
package nts_pkg;

   typedef enum logic [1:0] {
      RATIO_2 = 2'b00,
      RATIO_4 = 2'b01,
      RATIO_8 = 2'b10,
      RATIO_8B = 2'b11
   } ratio_e;

   // Number of bits serialized per word for a ratio code
   function automatic logic [3:0] ratio_len(input logic [1:0] code);
      logic [3:0] len;
      case (code)
         RATIO_2: len = 4'd2;
         RATIO_4: len = 4'd4;
         default: len = 4'd8;
      endcase
      return len;
   endfunction

endpackage

// File: rtl/nts_word_timer.sv
module nts_word_timer
   import nts_pkg::*;
#(
   parameter int MAX_LEN = 8,
   localparam int CW = $clog2(MAX_LEN)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] ratio_sel,
   output logic       load
);

   logic [CW-1:0] cnt;
   logic [3:0]    len;

   assign len  = ratio_len(ratio_sel);
   assign load = ({1'b0, cnt} >= ({1'b0, len} - 5'd1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= CW'(MAX_LEN - 1);
      end else if (load) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R2
   ld_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !load);

   // R2
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(load) && $stable(ratio_sel)) |-> ({1'b0, cnt} < {1'b0, len}));

endmodule

// File: rtl/nts_shift.sv
module nts_shift #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] din,
   output logic             bit_out
);

   logic [WIDTH-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (load) begin
         q <= din;
      end else begin
         q <= {1'b0, q[WIDTH-1:1]};
      end
   end

   assign bit_out = q[0];

endmodule

// File: rtl/nts_out_stage.sv
module nts_out_stage #(
   parameter bit GATED = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic use_wren,
   input  logic gate_en,
   input  logic t_raw,
   input  logic data_bit,
   input  logic wren_bit,
   output logic ser_bit,
   output logic t_bit
);

   generate
      if (GATED) begin : g_gated
         assign ser_bit = gate_en ? (data_bit & wren_bit) : data_bit;
      end else begin : g_free
         logic unused_gate;
         assign unused_gate = gate_en;
         assign ser_bit = data_bit;
      end
   endgenerate

   assign t_bit = use_wren ? ~wren_bit : t_raw;

   // R4
   traw_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !use_wren |-> (t_bit == t_raw));

   // R7
   gate_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (GATED && gate_en && use_wren && t_bit) |-> !ser_bit);

endmodule

// File: rtl/nibble_tx_serializer.sv
module nibble_tx_serializer
   import nts_pkg::*;
#(
   parameter int NSLICE = 6,
   parameter int DATA_W = 8,
   parameter int UNGATED_SLICE = 1,
   localparam int TOTAL_W = NSLICE * DATA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         ratio_sel,
   input  logic               gate_en,
   input  logic [NSLICE-1:0]  tsrc_sel,
   input  logic [TOTAL_W-1:0] tx_data,
   input  logic [DATA_W-1:0]  tx_wren,
   input  logic [NSLICE-1:0]  t_in,
   output logic               word_ld,
   output logic [NSLICE-1:0]  ser_out,
   output logic [NSLICE-1:0]  t_out,
   output logic               cfg_err
);

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("DATA_W must cover the 8:1 ratio");
      end
      if (UNGATED_SLICE >= NSLICE) begin : g_bad_exempt
         $error("UNGATED_SLICE out of range");
      end
   endgenerate

   logic              ratio_two;
   logic [NSLICE-1:0] use_wren;
   logic              wren_bit;

   assign ratio_two = (ratio_sel == RATIO_2);
   assign use_wren  = ratio_two ? '0 : tsrc_sel;
   assign cfg_err   = ratio_two && (|tsrc_sel);

   nts_word_timer #(.MAX_LEN(DATA_W)) i_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .ratio_sel (ratio_sel),
      .load      (word_ld)
   );

   nts_shift #(.WIDTH(DATA_W)) i_wren_sh (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (word_ld),
      .din     (tx_wren),
      .bit_out (wren_bit)
   );

   for (genvar s = 0; s < NSLICE; s++) begin : g_slice
      logic data_bit;

      nts_shift #(.WIDTH(DATA_W)) i_data_sh (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (word_ld),
         .din     (tx_data[s*DATA_W +: DATA_W]),
         .bit_out (data_bit)
      );

      nts_out_stage #(.GATED(s != UNGATED_SLICE)) i_out (
         .clk      (clk),
         .rst_n    (rst_n),
         .use_wren (use_wren[s]),
         .gate_en  (gate_en),
         .t_raw    (t_in[s]),
         .data_bit (data_bit),
         .wren_bit (wren_bit),
         .ser_bit  (ser_out[s]),
         .t_bit    (t_out[s])
      );
   end

   // R6
   ratio2_tri_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_two |-> (t_out == t_in));

   // R6
   cfg_err_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (ratio_sel == RATIO_2));

   // R9
   reset_ser_chk: assert property (@(posedge clk)
      !rst_n |-> (ser_out == '0));

endmodule

// File: tb/test_nibble_tx_serializer.sv
`timescale 1ns/1ps
module test_nibble_tx_serializer;

   localparam int NS = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  ratio_sel = 2'b10;
   logic        gate_en = 1'b0;
   logic [5:0]  tsrc_sel = '0;
   logic [47:0] tx_data = '0;
   logic [7:0]  tx_wren = '0;
   logic [5:0]  t_in = '0;
   logic        word_ld;
   logic [5:0]  ser_out;
   logic [5:0]  t_out;
   logic        cfg_err;

   always #2.5 clk = ~clk;

   nibble_tx_serializer i_nibble_tx_serializer (
      .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .gate_en(gate_en),
      .tsrc_sel(tsrc_sel), .tx_data(tx_data), .tx_wren(tx_wren), .t_in(t_in),
      .word_ld(word_ld), .ser_out(ser_out), .t_out(t_out), .cfg_err(cfg_err)
   );

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   // Reference model state: words held since the last load and bit position
   logic [7:0] m_d [NS];
   logic [7:0] m_w;
   int m_pos = 0;
   int m_since = 99;

   function automatic int len_of(input logic [1:0] c);
      if (c == 2'b00) return 2;
      if (c == 2'b01) return 4;
      return 8;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NS; i++) m_d[i] = '0;
         m_w = '0;
         m_pos = 0;
         m_since = 99;
      end else if (m_since + 1 >= len_of(ratio_sel)) begin
         for (int i = 0; i < NS; i++) m_d[i] = tx_data[i*8 +: 8];
         m_w = tx_wren;
         m_pos = 0;
         m_since = 0;
      end else begin
         m_since++;
         m_pos++;
      end
   end

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         logic [5:0] e_ser, e_t;
         logic e_ld, e_err, wb;
         int r;
         r = len_of(ratio_sel);
         wb = (m_pos < 8) ? m_w[m_pos] : 1'b0;
         e_err = (r == 2) && (|tsrc_sel);
         e_ld = rst_n && (m_since + 1 >= r);
         for (int i = 0; i < NS; i++) begin
            logic db;
            db = (m_pos < 8) ? m_d[i][m_pos] : 1'b0;
            e_ser[i] = (gate_en && i != 1) ? (db & wb) : db;
            e_t[i] = (tsrc_sel[i] && r != 2) ? ~wb : t_in[i];
         end
         if (!rst_n) begin
            check("R9 ser_out in reset", {2'b0, ser_out}, 8'h00);
            check("R9 t_out in reset", {2'b0, t_out}, {2'b0, e_t});
         end else begin
            check("R2 word_ld", {7'b0, word_ld}, {7'b0, e_ld});
            // R3 order, R7 gating on gated slices
            check(gate_en ? "R7 gated ser_out" : "R3 ser_out",
                  {2'b0, ser_out & 6'b111101}, {2'b0, e_ser & 6'b111101});
            check("R8 slice1 ungated", {7'b0, ser_out[1]}, {7'b0, e_ser[1]});
            check(r == 2 ? "R6 fallback t_out" : (|tsrc_sel ? "R5 t_out" : "R4 t_out"),
                  {2'b0, t_out}, {2'b0, e_t});
            check(r == 2 ? "R6 cfg_err" : "R1 cfg_err", {7'b0, cfg_err}, {7'b0, e_err});
         end
      end
   end

   task automatic run_phase(input logic [1:0] rs, input logic ge, input logic [5:0] ts, input int n);
      ratio_sel = rs;
      gate_en = ge;
      tsrc_sel = ts;
      for (int k = 0; k < n; k++) begin
         tx_data = {$urandom, $urandom};
         tx_wren = 8'($urandom);
         t_in = 6'($urandom);
         @(posedge clk);
         #1;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      run_phase(2'b10, 1'b0, 6'b000000, 200); // R3 R4 at 8:1
      run_phase(2'b10, 1'b0, 6'b101011, 200); // R5
      run_phase(2'b11, 1'b1, 6'b111111, 200); // R1 code 11, R7 R8
      run_phase(2'b01, 1'b1, 6'b010110, 200); // R1 4:1, R7
      run_phase(2'b01, 1'b0, 6'b000000, 120);
      run_phase(2'b00, 1'b0, 6'b000100, 150); // R6 error and fallback
      run_phase(2'b00, 1'b1, 6'b000000, 150); // R7 at 2:1 with raw T
      rst_n = 1'b0;
      tsrc_sel = 6'b111111;
      ratio_sel = 2'b10;
      repeat (4) @(posedge clk);
      #1;
      rst_n = 1'b1;                             // R9 and first load
      run_phase(2'b10, 1'b1, 6'b100001, 200);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule